// File: doc/BRIEF.md
# Write-Protection Command Sequence Guard

This block sits between the write qualifier of a parallel nonvolatile memory and its page buffer. It watches every qualified write, recognises short command sequences made of writes to fixed addresses with fixed data bytes, and keeps a protection flag. For each write it decides one of three outcomes. The write can go to the page buffer. It can be swallowed as part of a command. Or it can be blocked, in which case the block also starts a busy period that commits no data.

There are two command sequences. The lock sequence is three writes: 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0xA0 to 0x5555. It sets protection and opens a load window in which the following writes reach the buffer. The same three writes act as a prefix that lets data through while protection is already on. The release sequence is six writes: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. It clears protection.

A load-window timeout from the page timer abandons a partial sequence and closes an open window. The protection flag models nonvolatile storage. Only the one-time initial reset clears it. A power-cycle input restarts the detector and the outputs but leaves the flag unchanged.

Top module: `wpg_guard`

## Requirements
- R1: After `rst`, `prot_o` is 0, and `wr_o_vld` and `dummy_o` are 0 until a write is given.
- R2: The three writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 in consecutive order set `prot_o` to 1 one cycle after the third write. None of the three writes appears on `wr_o_vld`.
- R3: After a completed lock sequence, every following write passes to the output until the next timeout. This holds whether protection was on or off before the sequence.
- R4: While protected, a write that is neither a sequence step nor inside an open window gives no output write. It gives a one-cycle `dummy_o` pulse one cycle after the write.
- R5: The six-write release sequence (0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555) clears `prot_o` one cycle after the sixth write. None of the six writes is passed.
- R6: `pwr_cyc` restarts the detector and clears the output strobes but does not change `prot_o`. `prot_o` never changes in a cycle without a write.
- R7: While unprotected, a write that does not start a sequence appears on the output one cycle later with the same address and data, and with `dummy_o` 0. This includes writes to the command addresses with other data.
- R8: A write that does not match the next expected step returns the detector to its start. The mismatching write passes if unprotected and is blocked with a `dummy_o` pulse if protected. It is not itself taken as a first step.
- R9: `win_timeout` abandons a partial sequence and closes an open window. A write in the same cycle as the timeout is judged as if the detector were at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Initial reset, synchronous active high; clears everything including protection |
| pwr_cyc | input | 1 | Power transition; restarts detector and outputs, keeps protection |
| wr_vld | input | 1 | Qualified write request |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| win_timeout | input | 1 | Page load window expired |
| wr_o_vld | output | 1 | Filtered write to page buffer |
| wr_o_addr | output | AW | Filtered write address |
| wr_o_data | output | DW | Filtered write data |
| dummy_o | output | 1 | Pulse starting a busy period that commits nothing |
| prot_o | output | 1 | Protection flag |

## Verification
Every result of this block (the passed write, the dummy pulse and the new protection value) comes from a single register stage. It is therefore due exactly one clock after the edge that samples the write. The driver applies one input set per cycle at the falling edge and queues the outcome predicted for that input. The monitor pops one entry just after each following rising edge and compares all outputs together, so a wrong latency shows up as a mismatch. Sequences are driven back to back, with timeouts and power cycles placed between them, so that step order, abandonment and flag retention are each seen at that single-cycle offset.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

    localparam logic [15:0] KEY_ADDR_A = 16'h5555;
    localparam logic [15:0] KEY_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_DATA_1 = 8'hAA;
    localparam logic [7:0]  KEY_DATA_2 = 8'h55;
    localparam logic [7:0]  OP_LOCK    = 8'hA0;
    localparam logic [7:0]  OP_PREP    = 8'h80;
    localparam logic [7:0]  OP_RELEASE = 8'h20;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_KEY1,
        CMD_KEY2,
        CMD_LOCK,
        CMD_PREP,
        CMD_RELEASE
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_K1,
        ST_K2,
        ST_R3,
        ST_R4,
        ST_R5,
        ST_OPEN
    } seq_st_e;

    typedef struct packed {
        logic pass;
        logic dummy;
    } verdict_t;

    function automatic verdict_t reject(input logic prot);
        verdict_t v;
        v.pass  = ~prot;
        v.dummy = prot;
        return v;
    endfunction

endpackage

// File: rtl/wpg_matcher.sv
module wpg_matcher
    import wpg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output cmd_e          cmd
);
    localparam logic [AW-1:0] A_HI = AW'(KEY_ADDR_A);
    localparam logic [AW-1:0] A_LO = AW'(KEY_ADDR_B);
    localparam logic [DW-1:0] D_K1 = DW'(KEY_DATA_1);
    localparam logic [DW-1:0] D_K2 = DW'(KEY_DATA_2);
    localparam logic [DW-1:0] D_LK = DW'(OP_LOCK);
    localparam logic [DW-1:0] D_PR = DW'(OP_PREP);
    localparam logic [DW-1:0] D_RL = DW'(OP_RELEASE);

    logic at_hi, at_lo;

    always_comb begin
        at_hi = (addr == A_HI);
        at_lo = (addr == A_LO);
        cmd   = CMD_NONE;
        if (at_hi && data == D_K1)      cmd = CMD_KEY1;
        else if (at_lo && data == D_K2) cmd = CMD_KEY2;
        else if (at_hi && data == D_LK) cmd = CMD_LOCK;
        else if (at_hi && data == D_PR) cmd = CMD_PREP;
        else if (at_hi && data == D_RL) cmd = CMD_RELEASE;
    end
endmodule

// File: rtl/wpg_fsm.sv
module wpg_fsm
    import wpg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     pwr_cyc,
    input  logic     wr_vld,
    input  logic     win_timeout,
    input  cmd_e     cmd,
    output verdict_t verdict,
    output logic     prot
);
    seq_st_e st_q, st_d, cur;
    logic    prot_q, prot_d;
    logic    miss;

    always_comb begin
        cur     = win_timeout ? ST_IDLE : st_q;
        st_d    = cur;
        prot_d  = prot_q;
        miss    = 1'b0;
        verdict = '0;
        if (wr_vld) begin
            case (cur)
                ST_OPEN: verdict.pass = 1'b1;
                ST_IDLE: if (cmd == CMD_KEY1) st_d = ST_K1; else miss = 1'b1;
                ST_K1:   if (cmd == CMD_KEY2) st_d = ST_K2; else miss = 1'b1;
                ST_K2: begin
                    if (cmd == CMD_LOCK) begin
                        st_d   = ST_OPEN;
                        prot_d = 1'b1;
                    end else if (cmd == CMD_PREP) begin
                        st_d = ST_R3;
                    end else begin
                        miss = 1'b1;
                    end
                end
                ST_R3:   if (cmd == CMD_KEY1) st_d = ST_R4; else miss = 1'b1;
                ST_R4:   if (cmd == CMD_KEY2) st_d = ST_R5; else miss = 1'b1;
                ST_R5: begin
                    if (cmd == CMD_RELEASE) begin
                        st_d   = ST_IDLE;
                        prot_d = 1'b0;
                    end else begin
                        miss = 1'b1;
                    end
                end
                default: miss = 1'b1;
            endcase
            if (miss) begin
                st_d    = ST_IDLE;
                verdict = reject(prot_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pwr_cyc) st_q <= ST_IDLE;
        else                st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst)           prot_q <= 1'b0;
        else if (!pwr_cyc) prot_q <= prot_d;
    end

    assign prot = prot_q;

    AST_PROT_KEEP_PWR: assert property (@(posedge clk) disable iff (rst)
        pwr_cyc |=> $stable(prot_q)); // R6
    AST_PROT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wr_vld |=> $stable(prot_q)); // R6
    AST_PROT_RISE_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_q) |-> $past(cmd == CMD_LOCK && wr_vld)); // R2
    AST_PROT_FALL_REL: assert property (@(posedge clk) disable iff (rst)
        $fell(prot_q) |-> $past(cmd == CMD_RELEASE && wr_vld)); // R5
endmodule

// File: rtl/wpg_outreg.sv
module wpg_outreg
    import wpg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_cyc,
    input  logic          wr_vld,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  verdict_t      verdict,
    output logic          o_vld,
    output logic [AW-1:0] o_addr,
    output logic [DW-1:0] o_data,
    output logic          o_dummy
);
    always_ff @(posedge clk) begin
        if (rst || pwr_cyc) begin
            o_vld   <= 1'b0;
            o_dummy <= 1'b0;
            o_addr  <= '0;
            o_data  <= '0;
        end else begin
            o_vld   <= wr_vld & verdict.pass;
            o_dummy <= wr_vld & verdict.dummy;
            if (wr_vld && verdict.pass) begin
                o_addr <= wr_addr;
                o_data <= wr_data;
            end
        end
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(o_vld && o_dummy)); // R4
    AST_OUT_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        o_vld |-> $past(wr_vld)); // R7
    AST_DUMMY_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
        o_dummy |-> $past(wr_vld)); // R4
endmodule

// File: rtl/wpg_guard.sv
module wpg_guard
    import wpg_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_cyc,
    input  logic          wr_vld,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          win_timeout,
    output logic          wr_o_vld,
    output logic [AW-1:0] wr_o_addr,
    output logic [DW-1:0] wr_o_data,
    output logic          dummy_o,
    output logic          prot_o
);
    cmd_e     cmd;
    verdict_t verdict;
    logic     wr_q;

    wpg_matcher #(.AW(AW), .DW(DW)) u_match (
        .addr(wr_addr), .data(wr_data), .cmd(cmd)
    );

    wpg_fsm u_fsm (
        .clk(clk), .rst(rst), .pwr_cyc(pwr_cyc), .wr_vld(wr_q),
        .win_timeout(win_timeout), .cmd(cmd), .verdict(verdict), .prot(prot_o)
    );

    wpg_outreg #(.AW(AW), .DW(DW)) u_out (
        .clk(clk), .rst(rst), .pwr_cyc(pwr_cyc), .wr_vld(wr_q),
        .wr_addr(wr_addr), .wr_data(wr_data), .verdict(verdict),
        .o_vld(wr_o_vld), .o_addr(wr_o_addr), .o_data(wr_o_data),
        .o_dummy(dummy_o)
    );

    assign wr_q = wr_vld & ~rst & ~pwr_cyc;

    AST_SEQ_CLEAR_AFTER_RST: assert property (@(posedge clk)
        rst |=> (!wr_o_vld && !dummy_o && !prot_o)); // R1
endmodule

// File: tb/wpg_guard_tb.sv
module wpg_guard_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_cyc = 1'b0;
    logic        wr_vld = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        win_timeout = 1'b0;
    logic        wr_o_vld, dummy_o, prot_o;
    logic [15:0] wr_o_addr;
    logic [7:0]  wr_o_data;

    always #2.5 clk = ~clk;

    wpg_guard u_dut (
        .clk(clk), .rst(rst), .pwr_cyc(pwr_cyc), .wr_vld(wr_vld),
        .wr_addr(wr_addr), .wr_data(wr_data), .win_timeout(win_timeout),
        .wr_o_vld(wr_o_vld), .wr_o_addr(wr_o_addr), .wr_o_data(wr_o_data),
        .dummy_o(dummy_o), .prot_o(prot_o)
    );

    typedef struct {
        bit          v;
        logic [15:0] a;
        logic [7:0]  d;
        bit          dm;
        bit          p;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;
    int   step_m = 0;
    bit   prot_m = 0;

    task automatic cyc(input bit r, input bit pc, input bit w, input logic [15:0] a,
                       input logic [7:0] d, input bit to, input string tag);
        exp_t e;
        int   st;
        bit   miss;
        @(negedge clk);
        rst = r; pwr_cyc = pc; wr_vld = w; wr_addr = a; wr_data = d; win_timeout = to;
        e.v = 0; e.a = 'x; e.d = 'x; e.dm = 0; e.tag = tag;
        if (r) begin
            step_m = 0; prot_m = 0;
        end else if (pc) begin
            step_m = 0;
        end else begin
            st = to ? 0 : step_m;
            miss = 0;
            if (w) begin
                case (st)
                    6: begin e.v = 1; e.a = a; e.d = d; end
                    0, 3: if (a == 16'h5555 && d == 8'hAA) st = st + 1; else miss = 1;
                    1, 4: if (a == 16'h2AAA && d == 8'h55) st = st + 1; else miss = 1;
                    2: if (a == 16'h5555 && d == 8'hA0) begin st = 6; prot_m = 1; end
                       else if (a == 16'h5555 && d == 8'h80) st = 3;
                       else miss = 1;
                    5: if (a == 16'h5555 && d == 8'h20) begin st = 0; prot_m = 0; end
                       else miss = 1;
                    default: miss = 1;
                endcase
                if (miss) begin
                    st = 0;
                    if (prot_m) e.dm = 1;
                    else begin e.v = 1; e.a = a; e.d = d; end
                end
            end
            step_m = st;
        end
        e.p = prot_m;
        q.push_back(e);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        cyc(0, 0, 1, a, d, 0, tag);
    endtask

    task automatic idle(input bit to, input string tag);
        cyc(0, 0, 0, 16'h0, 8'h0, to, tag);
    endtask

    task automatic lock_seq(input string tag);
        wr(16'h5555, 8'hAA, tag); wr(16'h2AAA, 8'h55, tag); wr(16'h5555, 8'hA0, tag);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_cmp++;
                if (wr_o_vld !== e.v || dummy_o !== e.dm || prot_o !== e.p ||
                    (e.v && (wr_o_addr !== e.a || wr_o_data !== e.d))) begin
                    n_bad++;
                    $display("FAIL %s: got vld=%0b addr=%h data=%h dummy=%0b prot=%0b, expected vld=%0b addr=%h data=%h dummy=%0b prot=%0b",
                             e.tag, wr_o_vld, wr_o_addr, wr_o_data, dummy_o, prot_o,
                             e.v, e.a, e.d, e.dm, e.p);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected end of stimulus");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : driver
        cyc(1, 0, 0, 0, 0, 0, "R1");
        cyc(1, 0, 1, 16'h1234, 8'h77, 0, "R1");
        cyc(0, 0, 0, 0, 0, 0, "R1");
        idle(0, "R1");
        // R7 plain writes while unprotected, including command addresses
        wr(16'h1234, 8'h5A, "R7");
        wr(16'h5555, 8'h11, "R7");
        wr(16'h2AAA, 8'h55, "R7");
        idle(0, "R7");
        // R2 lock, then R3 window
        lock_seq("R2");
        wr(16'h0100, 8'h01, "R3");
        wr(16'h0101, 8'h02, "R3");
        idle(1, "R9");
        // R4 unprefixed write while protected
        wr(16'h0200, 8'h33, "R4");
        idle(0, "R4");
        // R3 prefixed write while protected
        lock_seq("R3");
        wr(16'h0300, 8'h44, "R3");
        idle(1, "R3");
        // R8 mismatch mid-sequence while protected, then restart
        wr(16'h5555, 8'hAA, "R8");
        wr(16'h1000, 8'h77, "R8");
        wr(16'h2AAA, 8'h55, "R8");
        lock_seq("R8");
        wr(16'h0400, 8'h66, "R8");
        idle(1, "R8");
        // R9 timeout abandons a partial sequence
        wr(16'h5555, 8'hAA, "R9");
        wr(16'h2AAA, 8'h55, "R9");
        idle(1, "R9");
        wr(16'h5555, 8'hA0, "R9");
        wr(16'h5555, 8'hAA, "R9");
        wr(16'h2AAA, 8'h55, "R9");
        cyc(0, 0, 1, 16'h5555, 8'hA0, 1, "R9");
        // R6 power cycle keeps protection
        cyc(0, 1, 0, 0, 0, 0, "R6");
        cyc(0, 1, 1, 16'h0500, 8'h12, 0, "R6");
        idle(0, "R6");
        wr(16'h0501, 8'h13, "R6");
        // R5 release sequence
        wr(16'h5555, 8'hAA, "R5"); wr(16'h2AAA, 8'h55, "R5"); wr(16'h5555, 8'h80, "R5");
        wr(16'h5555, 8'hAA, "R5"); wr(16'h2AAA, 8'h55, "R5"); wr(16'h5555, 8'h20, "R5");
        wr(16'h0600, 8'h99, "R5");
        // R8 mismatch while unprotected passes
        wr(16'h5555, 8'hAA, "R8");
        wr(16'h3333, 8'h12, "R8");
        // R3 lock from unprotected opens the window, R9 timeout closes it
        lock_seq("R3");
        wr(16'h0700, 8'hC3, "R3");
        cyc(0, 0, 1, 16'h0701, 8'hC4, 1, "R9");
        idle(0, "R9");
        repeat (3) @(posedge clk);
        #2;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule